// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Status Flags

This block is a serial peripheral port that moves one byte at a time over a four-wire serial link. A processor drives it through a small register port that holds a control register, a status register and a data register. In master mode the block generates the serial clock from the system clock through a programmable divider. In slave mode it follows a clock and a select line that an external master drives. Bit order, clock idle level and clock phase are programmable.

Software learns about finished transfers from a completion flag. That flag can also raise an interrupt request. A second flag reports a data write that arrives while a byte is still moving; such a write is dropped. Both flags clear when software reads the status register while a flag is set and then reads or writes the data register. The completion flag also clears on an acknowledge pulse. If the select input goes low while the block is a master, the block falls back to slave mode and raises the completion flag, so another master can take the bus.

Top module: `spi_port`

## Requirements
- R1: Register addresses are control=0, status=1 and data=2. Reads are combinational from the address. Control bits: 7 interrupt enable, 5 LSB-first, 4 master, 3 clock idle-high, 2 clock phase, 1:0 rate. Control bit 6 reads 0. All registers reset to 0.
- R2: With LSB-first at 1 the data bit 0 goes out first; with 0 bit 7 goes out first. The first bit is on the serial output in the cycle after the data write.
- R3: In master mode a data write while idle starts a transfer. The transfer lasts 8·D clocks, where D is 4, 16, 64 or 128 for rate codes 0, 1, 2 and 3. The completion flag reads 1 from the clock edge 8·D edges after the starting write edge.
- R4: The clock output rests at the idle-high bit's level whenever no transfer runs. In master mode it toggles once every D/2 clocks, 16 times per byte. The clock enable output equals the master bit.
- R5: Phase 0 samples on the leading clock edge and shifts on the trailing edge. Phase 1 shifts on the leading edge and samples on the trailing edge. With the serial output looped back to the input, the data register holds the sent byte after the transfer, in every mode.
- R6: The completion flag is status bit 7 and sets at the end of each byte. The interrupt output is the completion flag ANDed with the interrupt enable bit.
- R7: An acknowledge pulse clears the completion flag.
- R8: A status read while either flag is set, followed later by any data access, clears both flags. A flag that is set in the same cycle as the clearing access stays set.
- R9: The collision flag is status bit 6. It sets when the data register is written during a transfer. That write is dropped and the byte in flight is received intact.
- R10: Status bits 5 to 0 always read 0.
- R11: When the synchronized select input is low while the master bit is set, the master bit clears, any transfer stops and the completion flag sets. The block stays in slave mode until software sets the master bit again.
- R12: In slave mode the clock and select inputs pass a two-flop synchronizer. A pin edge takes effect on the third clock edge after it. A data write while idle preloads the outgoing byte. The 16th clock edge with select low completes the byte. The rate bits have no effect in slave mode.
- R13: Driving select high in slave mode drops a partial byte and restarts the bit count, and it raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe, which drives the clear sequence |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the selected register |
| intAck | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| ssN | input | 1 | Active-low select input |
| sckIn | input | 1 | Serial clock input (slave mode) |
| sckOut | output | 1 | Serial clock output (master mode) |
| sckOe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |

## Verification
Two pairs of events can land on the same clock edge. One is the final clock edge of a byte and the data access that finishes a clear sequence. The other is that final edge and a late data write. The bench starts a fast master transfer, causes a collision and reads status to arm the clear. It then uses a cycle counter to place a data read exactly on the completing edge. The behavioural model decides the outcome: the collision flag clears while the newly set completion flag survives. That is checked in the next status read and against the interrupt output on every clock.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int REG_W = 8;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       intEn;
    logic       lsbFirst;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctlReg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // take a new outgoing byte
    logic drive;   // present the next bit on the output
    logic sample;  // capture the input bit and shift
  } dpStb_t;
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int WORD_W = REG_W,
  parameter int DIV_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [REG_W-1:0] regWdata,
  input  logic             intAck,
  input  logic             ssN,
  input  logic             sckIn,
  output ctlReg_t          ctlQ,
  output logic             flagDone,
  output logic             flagCol,
  output logic             busyNow,
  output logic             sckOut,
  output dpStb_t           stb
);
  localparam int EDGES = 2 * WORD_W;
  localparam int CNT_W = $clog2(EDGES);

  logic [2:0]       sckSync;
  logic [1:0]       ssSync;
  logic             mBusy, sckPh, armed;
  logic [DIV_W-1:0] divCnt, halfM1;
  logic [CNT_W-1:0] edgeCnt;
  logic             unusedBit6;

  assign unusedBit6 = regWdata[6];

  // half SCK period minus one, in system clocks
  always_comb begin
    case (ctlQ.rate)
      2'd0:    halfM1 = DIV_W'(1);
      2'd1:    halfM1 = DIV_W'(7);
      2'd2:    halfM1 = DIV_W'(31);
      default: halfM1 = DIV_W'(63);
    endcase
  end

  logic ctlWr, statRd, dataAcc, dataWr, ssLow, fault;
  logic startM, divTick, slvEdge, edgeEv, lastEdge, leading, clrSeq;

  assign ctlWr    = regWr && regAddr == ADDR_CTL;
  assign statRd   = regRd && regAddr == ADDR_STAT;
  assign dataAcc  = (regWr || regRd) && regAddr == ADDR_DATA;
  assign dataWr   = regWr && regAddr == ADDR_DATA;
  assign ssLow    = !ssSync[1];
  assign busyNow  = mBusy || (edgeCnt != '0);
  assign fault    = ctlQ.master && ssLow;
  assign startM   = dataWr && ctlQ.master && !busyNow && !fault;
  assign divTick  = mBusy && divCnt == halfM1;
  assign slvEdge  = !ctlQ.master && ssLow && (sckSync[2] ^ sckSync[1]);
  assign edgeEv   = divTick || slvEdge;
  assign lastEdge = edgeEv && edgeCnt == CNT_W'(EDGES - 1);
  assign leading  = !edgeCnt[0];
  assign clrSeq   = dataAcc && armed;

  assign stb.load   = dataWr && !busyNow && !fault;
  assign stb.sample = edgeEv && (leading ^ ctlQ.cpha);
  assign stb.drive  = edgeEv && !(leading ^ ctlQ.cpha);
  assign sckOut     = ctlQ.cpol ^ sckPh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      ssSync  <= '1;
    end else begin
      sckSync <= {sckSync[1:0], sckIn};
      ssSync  <= {ssSync[0], ssN};
    end
  end

  // sequencing: divider, edge counter, master busy, clock phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckPh   <= 1'b0;
    end else if (fault) begin
      mBusy   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
      sckPh   <= 1'b0;
    end else begin
      if (startM) begin
        mBusy  <= 1'b1;
        divCnt <= '0;
        sckPh  <= 1'b0;
      end else if (mBusy) begin
        divCnt <= divTick ? '0 : divCnt + 1'b1;
      end
      if (edgeEv) begin
        edgeCnt <= lastEdge ? '0 : edgeCnt + 1'b1;
        if (lastEdge) mBusy <= 1'b0;
      end
      if (divTick) sckPh <= ~sckPh;
      if (!ctlQ.master && !ssLow) edgeCnt <= '0;
    end
  end

  // registers and flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ     <= '0;
      flagDone <= 1'b0;
      flagCol  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      if (ctlWr) ctlQ <= '{intEn: regWdata[7], lsbFirst: regWdata[5],
                           master: regWdata[4], cpol: regWdata[3],
                           cpha: regWdata[2], rate: regWdata[1:0]};
      if (fault) ctlQ.master <= 1'b0;
      flagDone <= lastEdge || fault || (flagDone && !clrSeq && !intAck);
      flagCol  <= (dataWr && busyNow) || (flagCol && !clrSeq);
      if (clrSeq)                          armed <= 1'b0;
      else if (statRd && (flagDone || flagCol)) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp
  import spi_port_pkg::*;
#(
  parameter int WORD_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStb_t            stb,
  input  logic              lsbFirst,
  input  logic [WORD_W-1:0] wdata,
  input  logic              sdi,
  output logic [WORD_W-1:0] shiftQ,
  output logic              txBit
);
  function automatic logic headBit(input logic [WORD_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[WORD_W-1];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      txBit  <= 1'b0;
    end else if (stb.load) begin
      shiftQ <= wdata;
      txBit  <= headBit(wdata, lsbFirst);
    end else begin
      if (stb.sample)
        shiftQ <= lsbFirst ? {sdi, shiftQ[WORD_W-1:1]} : {shiftQ[WORD_W-2:0], sdi};
      if (stb.drive)
        txBit <= headBit(shiftQ, lsbFirst);
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [REG_W-1:0] regWdata,
  output logic [REG_W-1:0] regRdata,
  input  logic             intAck,
  output logic             irq,
  input  logic             ssN,
  input  logic             sckIn,
  output logic             sckOut,
  output logic             sckOe,
  input  logic             sdi,
  output logic             sdo
);
  ctlReg_t          ctlQ;
  dpStb_t           stb;
  logic             flagDone, flagCol, busyNow;
  logic [REG_W-1:0] shiftQ;

  spi_port_ctrl #(.WORD_W(REG_W)) ctrlU (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .intAck(intAck), .ssN(ssN), .sckIn(sckIn),
    .ctlQ(ctlQ), .flagDone(flagDone), .flagCol(flagCol), .busyNow(busyNow),
    .sckOut(sckOut), .stb(stb)
  );

  spi_port_dp #(.WORD_W(REG_W)) dpU (
    .clk(clk), .rstN(rstN), .stb(stb), .lsbFirst(ctlQ.lsbFirst),
    .wdata(regWdata), .sdi(sdi), .shiftQ(shiftQ), .txBit(sdo)
  );

  assign irq   = flagDone && ctlQ.intEn;
  assign sckOe = ctlQ.master;

  always_comb begin
    case (regAddr)
      ADDR_CTL:  regRdata = {ctlQ.intEn, 1'b0, ctlQ.lsbFirst, ctlQ.master,
                             ctlQ.cpol, ctlQ.cpha, ctlQ.rate};
      ADDR_STAT: regRdata = {flagDone, flagCol, {(REG_W-2){1'b0}}};
      ADDR_DATA: regRdata = shiftQ;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk
  import spi_port_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] regAddr,
  input logic       regWr,
  input logic       intAck,
  input logic       sckOut,
  input logic       flagDone,
  input logic       flagCol,
  input logic       busyNow,
  input logic       ctlMaster,
  input logic       ctlCpol
);
  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagDone) |-> ($past(busyNow) || $fell(ctlMaster))); // R6

  AST_COLLISION_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_DATA && busyNow) |=> flagCol); // R9

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !busyNow |-> sckOut == ctlCpol); // R4

  AST_FAULT_SETS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ctlMaster) && !$past(regWr && regAddr == ADDR_CTL)) |-> flagDone); // R11

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !busyNow && !ctlMaster) |=> !flagDone); // R7
endmodule

bind spi_port spi_port_chk chkU (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .intAck(intAck),
  .sckOut(sckOut), .flagDone(flagDone), .flagCol(flagCol), .busyNow(busyNow),
  .ctlMaster(ctlQ.master), .ctlCpol(ctlQ.cpol)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic       clk = 1'b0, rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0, regRd = 1'b0, intAck = 1'b0;
  logic [7:0] regWdata = 8'd0, regRdata;
  logic       irq, ssN = 1'b1, sckIn = 1'b0, sckOut, sckOe, sdo;
  logic       loopEn = 1'b0, sdiDrv = 1'b0, sdi;
  int         nChecks = 0, nFails = 0, cyc = 0;
  bit         finished = 1'b0;

  assign sdi = loopEn ? sdo : sdiDrv;
  always #5 clk = ~clk;

  spi_port dut (.clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .intAck(intAck), .irq(irq), .ssN(ssN),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .sdi(sdi), .sdo(sdo));

  task automatic chk(input string req, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // behavioural reference model
  logic [7:0] mCtl;
  bit mSpif, mWcol, mArm, mBusy, ssq1, ssq2, sq1, sq2, sq3;
  int mCnt, mEdge;

  function automatic int periodOf(input logic [1:0] r);
    case (r) 2'd0: return 4; 2'd1: return 16; 2'd2: return 64; default: return 128; endcase
  endfunction

  always @(posedge clk) begin : model
    bit dAcc, dWr, sRd, cWr, busyPre, setD, setC, master, fault, clr;
    cyc++;
    if (!rstN) begin
      mCtl = 0; mSpif = 0; mWcol = 0; mArm = 0; mBusy = 0; mCnt = 0; mEdge = 0;
      ssq1 = 1; ssq2 = 1; sq1 = 0; sq2 = 0; sq3 = 0;
    end else begin
      dAcc = (regAddr == 2) && (regWr || regRd);
      dWr = (regAddr == 2) && regWr;
      sRd = (regAddr == 1) && regRd;
      cWr = (regAddr == 0) && regWr;
      busyPre = mBusy || mEdge != 0;
      setD = 0; setC = dWr && busyPre;
      master = mCtl[4];
      fault = master && !ssq2;
      if (fault) begin
        mBusy = 0; mEdge = 0; setD = 1;
      end else begin
        if (mBusy) begin
          mCnt++;
          if (mCnt == 8 * periodOf(mCtl[1:0])) begin mBusy = 0; setD = 1; end
        end else if (dWr && master && !busyPre) begin
          mBusy = 1; mCnt = 0;
        end
        if (!master) begin
          if (ssq2) mEdge = 0;
          else if (sq2 != sq3) begin
            mEdge++;
            if (mEdge == 16) begin mEdge = 0; setD = 1; end
          end
        end
      end
      clr = dAcc && mArm;
      if (clr) mArm = 0;
      else if (sRd && (mSpif || mWcol)) mArm = 1;
      mSpif = setD || (mSpif && !clr && !intAck);
      mWcol = setC || (mWcol && !clr);
      if (cWr) mCtl = regWdata & 8'hBF;
      if (fault) mCtl[4] = 0;
      sq3 = sq2; sq2 = sq1; sq1 = sckIn; ssq2 = ssq1; ssq1 = ssN;
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      int lvl;
      lvl = mBusy ? (mCtl[3] ^ ((mCnt / (periodOf(mCtl[1:0]) / 2)) % 2)) : mCtl[3];
      chk("R6 irq", irq, mSpif && mCtl[7]);
      chk("R4 sckOut", sckOut, lvl);
      chk("R4/R11 sckOe", sckOe, mCtl[4]);
    end
  end

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic busRd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a; regRd = 1'b1; #1 d = regRdata;
    @(negedge clk); regRd = 1'b0;
  endtask

  task automatic rdStatus(input string req);
    logic [7:0] v;
    logic [7:0] e;
    e = {mSpif, mWcol, 6'b0};
    busRd(2'd1, v);
    chk(req, v, e);
  endtask

  task automatic rdData(input string req, input logic [7:0] e);
    logic [7:0] v;
    busRd(2'd2, v);
    chk(req, v, e);
  endtask

  task automatic waitDone();
    while (!mSpif) @(negedge clk);
  endtask

  task automatic slaveBits(input logic [7:0] b, input int n, input bit chkTx, input logic [7:0] tx);
    for (int i = 0; i < n; i++) begin
      sdiDrv = b[7-i];
      repeat (6) @(negedge clk);
      if (chkTx) chk("R12 slave sdo bit", sdo, tx[7-i]);
      sckIn = 1'b1;
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1; nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    int startCyc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    busRd(2'd0, v); chk("R1 reset control", v, 8'h00);
    rdStatus("R10 reset status");
    chk("R4 reset sckOut", sckOut, 0);

    // R2 R3 R5 R6: master, phase 0, MSB first, fastest rate
    loopEn = 1'b1;
    busWr(2'd0, 8'hD0);          // bit6 written but reads 0
    busRd(2'd0, v); chk("R1 control readback", v, 8'h90);
    busWr(2'd2, 8'hA5);
    chk("R2 MSB first on sdo", sdo, 1);
    startCyc = cyc;
    waitDone();
    chk("R3 length rate0", cyc - startCyc, 32);
    rdStatus("R6 done flag status");
    rdData("R5 loopback phase0", 8'hA5);
    rdStatus("R8 flags cleared");

    // R2 R5 R7: LSB first, phase 1, idle high, slowest rate
    busWr(2'd0, 8'hBF);
    busWr(2'd2, 8'h3D);
    chk("R2 LSB first on sdo", sdo, 1);
    startCyc = cyc;
    waitDone();
    chk("R3 length rate3", cyc - startCyc, 1024);
    @(negedge clk); intAck = 1'b1; @(negedge clk); intAck = 1'b0;
    rdStatus("R7 ack clears");
    rdData("R5 loopback phase1", 8'h3D);

    // R9: collision at rate 1
    busWr(2'd0, 8'h91);
    busWr(2'd2, 8'h5A);
    repeat (10) @(negedge clk);
    busWr(2'd2, 8'hFF);
    waitDone();
    rdStatus("R9 collision status");
    chk("R9 status value", {mSpif, mWcol}, 2'b11);
    rdData("R9 byte intact", 8'h5A);
    rdStatus("R8 both cleared");

    // R8: clear access lands on the completing edge
    busWr(2'd0, 8'h90);
    busWr(2'd2, 8'h69);
    startCyc = cyc;
    busWr(2'd2, 8'h00);
    rdStatus("R8 armed read");
    while (cyc != startCyc + 31) @(negedge clk);
    rdData("R8 data at final edge", 8'h69);
    busRd(2'd1, v); chk("R8 set wins over clear", v, 8'h80);
    rdData("R8 second clear", 8'h69);
    rdStatus("R8 cleared");

    // R11: mode fault
    busWr(2'd0, 8'h10);
    ssN = 1'b0; repeat (4) @(negedge clk); ssN = 1'b1;
    repeat (3) @(negedge clk);
    busRd(2'd0, v); chk("R11 master cleared", v, 8'h00);
    rdStatus("R11 fault flag");
    busWr(2'd2, 8'h11);
    repeat (40) @(negedge clk);
    chk("R11 stays slave no transfer", sckOe, 0);
    rdData("R11 preload only", 8'h11);
    busRd(2'd1, v); chk("R11 cleared", v, 8'h00);

    // R12: slave receive and transmit, rate bits set but ignored
    loopEn = 1'b0;
    busWr(2'd0, 8'h83);
    busWr(2'd2, 8'hC3);
    ssN = 1'b0;
    slaveBits(8'h96, 8, 1'b1, 8'hC3);
    rdStatus("R12 slave done");
    rdData("R12 slave received", 8'h96);
    ssN = 1'b1; repeat (4) @(negedge clk);
    rdStatus("R12 cleared");

    // R13: partial byte dropped on select high
    ssN = 1'b0; repeat (4) @(negedge clk);
    slaveBits(8'hF0, 3, 1'b0, 8'h00);
    ssN = 1'b1; repeat (6) @(negedge clk);
    rdStatus("R13 no flag after abort");
    ssN = 1'b0; repeat (4) @(negedge clk);
    slaveBits(8'h4E, 8, 1'b0, 8'h00);
    rdStatus("R13 one flag after full byte");
    rdData("R13 fresh byte", 8'h4E);
    ssN = 1'b1;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule